// File: doc/BRIEF.md
# Channel Batch Bit Transposer

This block turns a stream of per-channel sample words into parallel multi-channel samples. Each input word carries a run of consecutive samples for one channel, earliest sample in the most significant bit. A static enable mask names which of the channels are present. The words of one batch arrive one per enabled channel, in ascending channel order. Once the last enabled channel of a batch has been received, the block plays out the batch as one sample word per time step. In each of those words, bit c is the level of channel c at that step.

The enable mask is held stable while the block is out of reset. It is changed only while reset is asserted. Input and output both use valid/ready handshakes. No input is taken while a finished batch is being played out. A batch that is only partly received is kept for as long as the input stays idle, so batches may straddle upstream packet boundaries. With an all-zero mask, every input word is accepted and thrown away, and nothing is ever emitted.

Top module: `chan_batch_transposer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Output sample k of a batch (k = 0 for the first sample played out) has bit c equal to bit (SPB-1-k) of the word received for enabled channel c.
- R3: Within a batch, the n-th accepted word (counting from 0) belongs to the n-th lowest set bit of `chan_mask`. After the last enabled channel, the next word starts a new batch at the lowest enabled channel.
- R4: Every output bit whose channel is clear in `chan_mask` is 0.
- R5: No data from an earlier batch appears in a later batch's samples.
- R6: Each batch produces exactly SPB output words. `out_last` is 1 on the final word and 0 on the others.
- R7: `in_ready` is 0 whenever `out_valid` is 1. It stays 0 from the cycle after the last word of a batch is accepted until the final output word is taken.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_sample` and `out_last` keep their values in the next cycle.
- R9: With `chan_mask` all zeros, `in_ready` stays 1, input words are consumed, and `out_valid` never rises.
- R10: A partly received batch is kept across any number of idle input cycles and completes correctly when input resumes.
- R11: With a single channel enabled, every accepted word forms a complete batch on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_mask | input | NCH | Enabled channels; stable outside reset |
| in_valid | input | 1 | Input word offered |
| in_word | input | SPB | Samples of one channel, MSB earliest |
| in_ready | output | 1 | Block accepts an input word |
| out_valid | output | 1 | Output sample offered |
| out_ready | input | 1 | Consumer takes the output sample |
| out_sample | output | NCH | One parallel sample, bit per channel |
| out_last | output | 1 | Final sample of the batch |

## Verification
The embedded assertions check the cycle-level rules on every cycle: input is stalled during playback, output is held under backpressure, disabled channel bits stay zero, an all-zero mask stays silent, the position pointer stays within the enabled count, and playback only ends after the flagged last word. Whether each bit lands in the right channel and time slot, whether channel order follows the mask, whether earlier batches leave anything behind, and whether partial batches survive idle gaps can only be seen from the bench's scenarios. The bench covers these with random masks and data, repeated all-ones/all-zeros batches, single-channel masks and long input gaps.

// File: rtl/cbt_pkg.sv
// Shared types for the channel batch transposer.
package cbt_pkg;
    // Sequencer phase: collecting channel words, or playing a batch out.
    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_DRAIN = 1'b1
    } cbt_phase_e;
endpackage

// File: rtl/cbt_order_map.sv
// Builds the ordered list of enabled channels from the enable mask and
// returns the channel for a given batch position together with the count.
// Assumes the mask is static while it is in use.
module cbt_order_map #(
    parameter int NCH   = 16,
    parameter int IDX_W = $clog2(NCH),
    parameter int CNT_W = $clog2(NCH + 1)
) (
    input  logic [NCH-1:0]   mask,
    input  logic [IDX_W-1:0] pos,
    output logic [IDX_W-1:0] chan,
    output logic [CNT_W-1:0] count
);
    logic [IDX_W-1:0] pos_chan [NCH];

    // Compact the set bits of the mask into an ascending channel list.
    always_comb begin
        count = '0;
        for (int p = 0; p < NCH; p++) pos_chan[p] = '0;
        for (int c = 0; c < NCH; c++) begin
            if (mask[c]) begin
                pos_chan[count[IDX_W-1:0]] = IDX_W'(c);
                count = count + CNT_W'(1);
            end
        end
    end

    // Look up the channel that owns the current batch position.
    always_comb chan = pos_chan[pos];
endmodule

// File: rtl/cbt_sample_store.sv
// Holds one batch as SPB parallel samples of NCH bits. A write scatters the
// bits of one channel word across all samples (MSB into sample 0). The
// first write of a batch clears every other channel bit as well.
module cbt_sample_store #(
    parameter int NCH   = 16,
    parameter int SPB   = 32,
    parameter int IDX_W = $clog2(NCH),
    parameter int SEL_W = $clog2(SPB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_first,
    input  logic [IDX_W-1:0] wr_chan,
    input  logic [SPB-1:0]   wr_word,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [NCH-1:0]   rd_sample
);
    logic [NCH-1:0] smp [SPB];

    for (genvar k = 0; k < SPB; k++) begin : g_slot
        logic [NCH-1:0] nxt;

        // Next value of sample k: cleared on batch start, one channel bit replaced.
        always_comb begin
            nxt          = wr_first ? '0 : smp[k];
            nxt[wr_chan] = wr_word[SPB-1-k];
        end

        // Register sample k on every accepted channel word.
        always_ff @(posedge clk) begin
            if (!rst_n)     smp[k] <= '0;
            else if (wr_en) smp[k] <= nxt;
        end
    end

    // Present the sample currently selected for playback.
    always_comb rd_sample = smp[rd_sel];
endmodule

// File: rtl/cbt_sequencer.sv
// Tracks the batch position during fill and the sample index during
// playback. Stalls input while draining. A zero count means no channel is
// enabled: words are then accepted and discarded.
module cbt_sequencer
    import cbt_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int SPB   = 32,
    parameter int IDX_W = $clog2(NCH),
    parameter int CNT_W = $clog2(NCH + 1),
    parameter int SEL_W = $clog2(SPB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_last,
    output logic [IDX_W-1:0] pos,
    output logic [SEL_W-1:0] sel,
    output logic             wr_en,
    output logic             wr_first
);
    localparam logic [SEL_W-1:0] SEL_END = SEL_W'(SPB - 1);

    cbt_phase_e phase;
    logic       take_in, take_out, pos_end;

    // Handshake decode and batch-end detection.
    always_comb begin
        in_ready  = (phase == ST_FILL);
        out_valid = (phase == ST_DRAIN);
        out_last  = out_valid && (sel == SEL_END);
        take_in   = in_valid && in_ready;
        take_out  = out_valid && out_ready;
        wr_en     = take_in && (count != '0);
        wr_first  = (pos == '0);
        pos_end   = (CNT_W'(pos) == count - CNT_W'(1));
    end

    // Phase, position and playback index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= ST_FILL;
            pos   <= '0;
            sel   <= '0;
        end else if (phase == ST_FILL) begin
            if (wr_en) begin
                if (pos_end) begin
                    pos   <= '0;
                    phase <= ST_DRAIN;
                end else begin
                    pos <= pos + IDX_W'(1);
                end
            end
        end else if (take_out) begin
            if (sel == SEL_END) begin
                sel   <= '0;
                phase <= ST_FILL;
            end else begin
                sel <= sel + SEL_W'(1);
            end
        end
    end

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |-> (CNT_W'(pos) < count)); // R3

    AST_PLAYBACK_ENDS_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> $past(out_last)); // R6
endmodule

// File: rtl/chan_batch_transposer.sv
// Top level: converts per-channel sample words, received round-robin over
// the enabled channels, into parallel samples with one bit per channel.
// Assumes chan_mask only changes while rst_n is low.
module chan_batch_transposer #(
    parameter int NCH = 16,
    parameter int SPB = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] chan_mask,
    input  logic           in_valid,
    input  logic [SPB-1:0] in_word,
    output logic           in_ready,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [NCH-1:0] out_sample,
    output logic           out_last
);
    localparam int IDX_W = $clog2(NCH);
    localparam int CNT_W = $clog2(NCH + 1);
    localparam int SEL_W = $clog2(SPB);

    logic [IDX_W-1:0] pos, chan;
    logic [CNT_W-1:0] count;
    logic [SEL_W-1:0] sel;
    logic             wr_en, wr_first;

    cbt_order_map #(.NCH(NCH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_map (
        .mask  (chan_mask),
        .pos   (pos),
        .chan  (chan),
        .count (count)
    );

    cbt_sequencer #(.NCH(NCH), .SPB(SPB), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (count),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_last  (out_last),
        .pos       (pos),
        .sel       (sel),
        .wr_en     (wr_en),
        .wr_first  (wr_first)
    );

    cbt_sample_store #(.NCH(NCH), .SPB(SPB), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_first  (wr_first),
        .wr_chan   (chan),
        .wr_word   (in_word),
        .rd_sel    (sel),
        .rd_sample (out_sample)
    );

    AST_STALL_DURING_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R7

    AST_HOLD_UNDER_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) && $stable(out_last))); // R8

    AST_DISABLED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_sample & ~chan_mask) == '0)); // R4

    AST_ZERO_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mask == '0) |-> (!out_valid && in_ready)); // R9
endmodule

// File: tb/chan_batch_transposer_test.sv
module chan_batch_transposer_test;
    localparam int NCH = 16;
    localparam int SPB = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] chan_mask = '0;
    logic           in_valid = 1'b0;
    logic [SPB-1:0] in_word = '0;
    logic           in_ready;
    logic           out_valid;
    logic           out_ready = 1'b1;
    logic [NCH-1:0] out_sample;
    logic           out_last;

    int checks = 0;
    int errors = 0;
    logic [SPB-1:0] wq [NCH];

    chan_batch_transposer #(.NCH(NCH), .SPB(SPB)) uut (
        .clk(clk), .rst_n(rst_n), .chan_mask(chan_mask),
        .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_sample(out_sample), .out_last(out_last)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish act=%0d exp=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    // Expected sample k from the requirements: n-th word -> n-th enabled channel.
    function automatic logic [NCH-1:0] exp_smp(input logic [NCH-1:0] m, input int k);
        logic [NCH-1:0] r = '0;
        int n = 0;
        for (int c = 0; c < NCH; c++) begin
            if (m[c]) begin
                r[c] = wq[n][SPB-1-k];
                n++;
            end
        end
        return r;
    endfunction

    task automatic do_reset(input logic [NCH-1:0] m);
        @(negedge clk);
        rst_n = 1'b0;
        chan_mask = m;
        in_valid = 1'b0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 reset state", {out_valid, in_ready}, 32'h1);
    endtask

    task automatic push(input logic [SPB-1:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word = w;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    // mode 0 random, 1 all ones, 2 all zeros, 3 random with long gaps
    task automatic run_batch(input int mode, input string tag);
        int n = $countones(chan_mask);
        for (int i = 0; i < NCH; i++) begin
            case (mode)
                1: wq[i] = '1;
                2: wq[i] = '0;
                default: wq[i] = $urandom;
            endcase
        end
        for (int i = 0; i < n; i++) begin
            push(wq[i]);
            if (i != n - 1) begin
                int gap = (mode == 3) ? 60 : int'($urandom % 3);
                @(negedge clk);
                in_valid = 1'b0;
                for (int g = 0; g < gap; g++) @(negedge clk);
                if (gap > 0) chk(!out_valid, "R10 partial batch held idle", {31'b0, out_valid}, 32'h0);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && !in_ready, "R7 input stalled while draining", {out_valid, in_ready}, 32'h2);
        for (int k = 0; k < SPB; k++) begin
            logic [NCH-1:0] e = exp_smp(chan_mask, k);
            if ($urandom % 4 == 0) begin
                logic [NCH-1:0] held = out_sample;
                logic hl = out_last;
                out_ready = 1'b0;
                @(posedge clk);
                @(negedge clk);
                chk(out_valid && out_sample == held && out_last == hl, "R8 held under backpressure",
                    {out_valid, out_last, out_sample}, {1'b1, hl, held});
                out_ready = 1'b1;
            end
            chk(out_valid && out_sample == e, {"R2 sample / ", tag}, {out_valid, out_sample}, {1'b1, e});
            chk((out_sample & ~chan_mask) == '0, "R4 disabled bits zero", out_sample, out_sample & chan_mask);
            chk(out_last == (k == SPB - 1), "R6 last flag position", {31'b0, out_last}, {31'b0, k == SPB - 1});
            @(posedge clk);
            @(negedge clk);
        end
        chk(!out_valid && in_ready, "R6 batch length exact", {out_valid, in_ready}, 32'h1);
    endtask

    initial begin
        void'($urandom(32'd20240611));

        // Zero mask: everything dropped.
        do_reset('0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_word = $urandom;
            chk(in_ready, "R9 zero mask accepts input", {31'b0, in_ready}, 32'h1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk(!out_valid, "R9 zero mask emits nothing", {31'b0, out_valid}, 32'h0);
        end

        // Directed masks.
        do_reset(16'hFFFF);
        run_batch(0, "R3 full mask");
        run_batch(1, "R5 all ones");
        run_batch(2, "R5 all zeros after ones");

        do_reset(16'h0001);
        run_batch(0, "R11 single low channel");
        run_batch(0, "R11 single low channel again");

        do_reset(16'h8000);
        run_batch(1, "R11 single high channel");
        run_batch(2, "R5 single high channel cleared");

        do_reset(16'hA5A5);
        run_batch(3, "R10 gaps between words");
        run_batch(0, "R3 sparse mask order");

        // Random masks and data.
        for (int t = 0; t < 12; t++) begin
            logic [NCH-1:0] m = NCH'($urandom);
            if (m == '0) m = 16'h0100;
            do_reset(m);
            for (int b = 0; b < 3; b++) run_batch(0, "R3 random mask");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule